// File: doc/BRIEF.md
# Receive Word Aligner with Slip Tracking

This block sits behind a raw serial receiver that has no line coding, so every received 32-bit word may be cut from the bit stream at an arbitrary bit boundary. The transmitter inserts a fixed alignment word into the stream. The block keeps the last valid word, joins it with the current one, and looks for the alignment word at every bit offset in the joined 64 bits. When it finds the word, it locks to that offset and from then on emits correctly framed words together with a valid flag.

The bit offset can drift partway through a transfer. The block keeps watching for the alignment word while locked. It moves to a new offset only after the alignment word has shown up twice in a row at that same new offset, and it signals each move with a one-cycle event. If the alignment word stays away too long, the block drops lock and searches again without any reset.

Received beats whose data-valid bit is low are ignored entirely.

Top module: `rx_word_aligner`

## Requirements
- R1: While reset is high and after it is released, `locked`, `out_valid` and `realign` are 0 and `slip` is 0. The held previous word is cleared, so the first valid beat after reset is searched against an all-zero previous word.
- R2: While unlocked, a valid beat locks the block with `slip` = k when the alignment word (default 0xF0000000) equals bits [63-k:32-k] of the 64-bit value {previous valid word, current word}, for some k in 0..31. If more than one k matches, the lowest k wins.
- R3: While locked, every valid beat yields, on the next cycle, `out_valid` = 1 and `out_word` = bits [63-s:32-s] of {previous, current}, where s is the offset in force after that beat. The beat that first acquires lock outputs the alignment word.
- R4: With a nonzero slip, each output word joins the low bits of the earlier received word with the high bits of the later one. A transmitted sequence sent through a slipped link comes out in its original order and value, for example 0x55555555, 0x5fffffff, 0x2a000000, 0x17a00000, 0x0aaa0000.
- R5: A beat with `in_valid` = 0 produces no output, leaves `locked` and `slip` unchanged, does not advance the search, and does not replace the held previous word.
- R6: While locked, a single occurrence of the alignment word at an offset different from `slip` does not change `slip`. An occurrence at the locked offset cancels such a pending candidate.
- R7: When the alignment word appears at the same new offset on two consecutive occurrences, `slip` moves to that offset, `realign` is 1 for exactly one cycle, and that beat's output is the alignment word.
- R8: While locked, LOSS_WORDS consecutive valid beats without the alignment word at the locked offset clear `locked` on the last of those beats, and that beat is not output. After that, searching resumes and the block can relock without a reset.
- R9: While unlocked, `out_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive word clock |
| rst | input | 1 | Synchronous active-high reset |
| in_word | input | W | Unaligned received word; the earlier bits of the stream are in the MSBs |
| in_valid | input | 1 | Beat qualifier; a low value means the beat is ignored |
| out_word | output | W | Framed word, meaningful when out_valid is 1 |
| out_valid | output | 1 | A framed word is present this cycle |
| locked | output | 1 | An alignment offset is held |
| slip | output | log2(W) | Bit offset currently applied |
| realign | output | 1 | One-cycle pulse when the offset moves while locked |

## Verification
The embedded properties check these rules on every cycle:
- A gap beat never produces output and never moves `slip` or `locked`.
- Output only appears while locked.
- Gaining lock and every realignment both present the alignment word.
- `slip` changes only on acquisition or on a realign event.
- A move is always preceded by an armed candidate at the same offset.
- Losing lock is silent.

Only the bench scenarios can show the following:
- A slipped stream is rebuilt word for word.
- A single stray occurrence, or an interrupted pair of occurrences, leaves the offset alone.
- Lock survives exactly LOSS_WORDS-1 silent words, drops on the next one, and comes back without a reset.

// File: rtl/wal_pkg.sv
package wal_pkg;

    // Decision taken by the lock tracker on one beat
    typedef enum logic [2:0] {
        ACT_IDLE,     // no valid beat, or hunting without a match
        ACT_ACQUIRE,  // first match while unlocked
        ACT_KEEP,     // match at the locked offset
        ACT_MOVE,     // second consecutive match at a new offset
        ACT_MISS,     // no match at the locked offset, window not expired
        ACT_DROP      // miss window expired
    } trk_act_e;

endpackage

// File: rtl/wal_search.sv
// Compares every bit offset of the joined word pair against the pattern
// and reports the lowest matching offset.
module wal_search #(
    parameter int W = 32,
    parameter logic [W-1:0] PATTERN = 32'hF000_0000,
    localparam int OFFW = $clog2(W)
) (
    input  logic [2*W-2:0]  span,     // {previous, current[W-1:1]}
    output logic            hit,
    output logic [OFFW-1:0] hit_off
);

    logic [W-1:0] match;

    for (genvar k = 0; k < W; k++) begin : g_cmp
        assign match[k] = (span[2*W-2-k -: W] == PATTERN);
    end

    always_comb begin
        hit     = |match;
        hit_off = '0;
        for (int k = W - 1; k >= 0; k--) begin
            if (match[k]) begin
                hit_off = OFFW'(k);
            end
        end
    end

endmodule

// File: rtl/wal_extract.sv
// Barrel extraction of one word from the joined pair at a given offset.
module wal_extract #(
    parameter int W = 32,
    localparam int OFFW = $clog2(W)
) (
    input  logic [2*W-2:0]  span,
    input  logic [OFFW-1:0] off,
    output logic [W-1:0]    word
);

    logic [W-1:0] win [W];

    for (genvar k = 0; k < W; k++) begin : g_win
        assign win[k] = span[2*W-2-k -: W];
    end

    assign word = win[off];

endmodule

// File: rtl/wal_track.sv
// Lock state: acquisition, confirmation of a moved offset, loss timeout.
module wal_track
    import wal_pkg::*;
#(
    parameter int OFFW       = 5,
    parameter int LOSS_WORDS = 16,
    localparam int CW        = $clog2(LOSS_WORDS + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            beat,
    input  logic            hit,
    input  logic [OFFW-1:0] hit_off,
    output logic            locked,
    output logic [OFFW-1:0] off,
    output logic            realign,
    output logic            nxt_locked,
    output logic [OFFW-1:0] nxt_off
);

    typedef struct packed {
        logic            locked;
        logic [OFFW-1:0] off;
        logic [OFFW-1:0] cand;
        logic            armed;
        logic [CW-1:0]   miss;
        logic            realign;
    } trk_t;

    trk_t     st_d, st_q;
    trk_act_e act;

    always_comb begin
        st_d         = st_q;
        st_d.realign = 1'b0;
        act          = ACT_IDLE;

        if (beat) begin
            if (!st_q.locked) begin
                if (hit) act = ACT_ACQUIRE;
            end else if (hit && hit_off == st_q.off) begin
                act = ACT_KEEP;
            end else if (hit && st_q.armed && hit_off == st_q.cand) begin
                act = ACT_MOVE;
            end else if (st_q.miss == CW'(LOSS_WORDS - 1)) begin
                act = ACT_DROP;
            end else begin
                act = ACT_MISS;
            end
        end

        case (act)
            ACT_ACQUIRE: begin
                st_d.locked = 1'b1;
                st_d.off    = hit_off;
                st_d.miss   = '0;
                st_d.armed  = 1'b0;
            end
            ACT_KEEP: begin
                st_d.miss  = '0;
                st_d.armed = 1'b0;
            end
            ACT_MOVE: begin
                st_d.off     = hit_off;
                st_d.realign = 1'b1;
                st_d.miss    = '0;
                st_d.armed   = 1'b0;
            end
            ACT_MISS: begin
                st_d.miss = st_q.miss + 1'b1;
                if (hit) begin
                    st_d.cand  = hit_off;
                    st_d.armed = 1'b1;
                end
            end
            ACT_DROP: begin
                st_d.locked = 1'b0;
                st_d.miss   = '0;
                st_d.armed  = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked     = st_q.locked;
    assign off        = st_q.off;
    assign realign    = st_q.realign;
    assign nxt_locked = st_d.locked;
    assign nxt_off    = st_d.off;

    // R7
    move_after_arm_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.realign |-> ($past(st_q.armed) && $past(st_q.cand) == st_q.off));

endmodule

// File: rtl/rx_word_aligner.sv
module rx_word_aligner #(
    parameter int W                 = 32,
    parameter logic [W-1:0] PATTERN = 32'hF000_0000,
    parameter int LOSS_WORDS        = 16,
    localparam int OFFW             = $clog2(W)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [W-1:0]    in_word,
    input  logic            in_valid,
    output logic [W-1:0]    out_word,
    output logic            out_valid,
    output logic            locked,
    output logic [OFFW-1:0] slip,
    output logic            realign
);

    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] data;
        logic         valid;
    } dp_t;

    dp_t dp_d, dp_q;

    logic [2*W-2:0] span;
    logic           hit;
    logic [OFFW-1:0] hit_off;
    logic [OFFW-1:0] nxt_off;
    logic           nxt_locked;
    logic [W-1:0]   ext_word;

    // The last bit of the current word never starts a window, so it is left out
    assign span = {dp_q.prev, in_word[W-1:1]};

    wal_search #(.W(W), .PATTERN(PATTERN)) u_search (
        .span    (span),
        .hit     (hit),
        .hit_off (hit_off)
    );

    wal_track #(.OFFW(OFFW), .LOSS_WORDS(LOSS_WORDS)) u_track (
        .clk        (clk),
        .rst        (rst),
        .beat       (in_valid),
        .hit        (hit),
        .hit_off    (hit_off),
        .locked     (locked),
        .off        (slip),
        .realign    (realign),
        .nxt_locked (nxt_locked),
        .nxt_off    (nxt_off)
    );

    wal_extract #(.W(W)) u_extract (
        .span (span),
        .off  (nxt_off),
        .word (ext_word)
    );

    always_comb begin
        dp_d       = dp_q;
        dp_d.valid = in_valid && nxt_locked;
        if (in_valid) begin
            dp_d.prev = in_word;
        end
        if (in_valid && nxt_locked) begin
            dp_d.data = ext_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign out_word  = dp_q.data;
    assign out_valid = dp_q.valid;

    // R5
    gap_no_emit_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R5
    gap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(slip) && $stable(locked) && !realign));

    // R9
    emit_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> locked);

    // R3
    acquire_word_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> (out_valid && out_word == PATTERN));

    // R7
    realign_word_chk: assert property (@(posedge clk) disable iff (rst)
        realign |-> (locked && out_valid && out_word == PATTERN && slip != $past(slip)));

    // R6
    slip_move_reason_chk: assert property (@(posedge clk) disable iff (rst)
        (slip != $past(slip)) |-> (realign || $rose(locked)));

    // R8
    drop_silent_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> !out_valid);

endmodule

// File: tb/sim_rx_word_aligner.sv
module sim_rx_word_aligner;

    localparam int W            = 32;
    localparam int LOSS         = 16;
    localparam logic [31:0] ALN = 32'hF000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] in_word = '0;
    logic        in_valid = 1'b0;
    logic [31:0] out_word;
    logic        out_valid;
    logic        locked;
    logic [4:0]  slip;
    logic        realign;

    always #5 clk = ~clk;

    rx_word_aligner #(.W(W), .PATTERN(ALN), .LOSS_WORDS(LOSS)) u0 (
        .clk(clk), .rst(rst), .in_word(in_word), .in_valid(in_valid),
        .out_word(out_word), .out_valid(out_valid), .locked(locked),
        .slip(slip), .realign(realign)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // transmitted stream and receiver bit position
    logic [31:0] tx [0:8191];
    int ntx = 0;
    int p   = 0;

    // reference model state
    logic [31:0] m_prev;
    bit m_locked, m_armed, exp_v, exp_r;
    int m_off, m_cand, m_miss;
    logic [31:0] exp_w;

    // observation
    logic [31:0] obs [0:63];
    int nobs, rcount, ndrop, since_align, gap_emit;
    logic [31:0] realign_word;
    bit prev_lk, last_v;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_prev = '0; m_locked = 0; m_armed = 0; m_off = 0; m_cand = 0; m_miss = 0;
        exp_v = 0; exp_r = 0; exp_w = '0; prev_lk = 0; last_v = 1;
    endtask

    task automatic model(input logic v, input logic [31:0] w);
        logic [63:0] cat, sh;
        bit found;
        int fk;
        exp_v = 0; exp_r = 0;
        if (!v) return;
        cat = {m_prev, w}; found = 0; fk = 0;
        for (int k = 0; k < 32; k++) begin
            sh = cat << k;
            if (!found && sh[63:32] == ALN) begin found = 1; fk = k; end
        end
        if (!m_locked) begin
            if (found) begin m_locked = 1; m_off = fk; m_miss = 0; m_armed = 0; end
        end else if (found && fk == m_off) begin
            m_miss = 0; m_armed = 0;
        end else if (found && m_armed && fk == m_cand) begin
            m_off = fk; exp_r = 1; m_miss = 0; m_armed = 0;
        end else begin
            if (found) begin m_cand = fk; m_armed = 1; end
            m_miss++;
            if (m_miss == LOSS) begin m_locked = 0; m_miss = 0; m_armed = 0; end
        end
        if (m_locked) begin
            exp_v = 1; sh = cat << m_off; exp_w = sh[63:32];
        end
        m_prev = w;
    endtask

    task automatic observe();
        chk("R9 out_valid vs model", 32'(out_valid), 32'(exp_v));
        if (exp_v) chk("R3 out_word vs model", out_word, exp_w);
        chk("R2 slip vs model", 32'(slip), 32'(m_off));
        chk("R8 locked vs model", 32'(locked), 32'(m_locked));
        chk("R7 realign vs model", 32'(realign), 32'(exp_r));
        if (!last_v && out_valid) gap_emit++;
        if (out_valid) begin
            if (nobs < 64) obs[nobs] = out_word;
            nobs++;
            if (out_word == ALN) since_align = 0; else since_align++;
        end
        if (realign) begin rcount++; realign_word = out_word; end
        if (prev_lk && !locked) ndrop++;
        prev_lk = locked;
    endtask

    task automatic beat(input logic v, input logic [31:0] w);
        @(negedge clk);
        observe();
        in_valid = v; in_word = w; last_v = v;
        model(v, w);
    endtask

    task automatic settle();
        beat(1'b0, $urandom);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    function automatic logic [31:0] get32(input int pos);
        int wi = pos / 32;
        int b  = pos % 32;
        logic [63:0] c = {tx[wi], tx[wi+1]};
        c = c << b;
        return c[63:32];
    endfunction

    function automatic logic [31:0] filler();
        return $urandom | 32'h0001_0001;
    endfunction

    task automatic push(input logic [31:0] w);
        tx[ntx] = w; ntx++;
    endtask

    task automatic push_fill(input int n);
        for (int i = 0; i < n; i++) push(filler());
    endtask

    task automatic flush(input int gap_pct);
        while (p / 32 + 1 < ntx) begin
            if (int'($urandom % 100) < gap_pct) beat(1'b0, $urandom);
            beat(1'b1, get32(p));
            p += 32;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL R1 watchdog: actual %0d cycles elapsed, expected completion", 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int rc0, nd0, delta, r;
        void'($urandom(32'd20240611));
        nobs = 0; rcount = 0; ndrop = 0; since_align = 0; gap_emit = 0; realign_word = '0;

        // R1: reset state
        do_reset();
        chk("R1 locked after reset", 32'(locked), 0);
        chk("R1 out_valid after reset", 32'(out_valid), 0);
        chk("R1 slip after reset", 32'(slip), 0);
        chk("R1 realign after reset", 32'(realign), 0);

        // R1: previous word is cleared by reset
        beat(1'b1, 32'h0000_000F);
        settle();
        do_reset();
        beat(1'b1, 32'h0000_0000);
        settle();
        chk("R1 no lock from pre-reset word", 32'(locked), 0);
        chk("R1 no output from pre-reset word", 32'(nobs), 0);

        // R9: payload without alignment word, receiver 13 bits late
        p = 13;
        push_fill(6);
        flush(0);
        settle();
        chk("R9 no output while hunting", 32'(nobs), 0);
        chk("R9 still unlocked", 32'(locked), 0);

        // R2, R3, R4: acquisition and reconstruction of the seed sequence
        nobs = 0;
        push(ALN);
        push(32'h5555_5555); push(32'h5fff_ffff); push(32'h2a00_0000);
        push(32'h17a0_0000); push(32'h0aaa_0000);
        push_fill(2);
        flush(30);
        settle();
        chk("R2 slip after acquire", 32'(slip), 19);
        chk("R2 locked after acquire", 32'(locked), 1);
        chk("R3 first word is alignment word", obs[0], ALN);
        chk("R4 seed word 0", obs[1], 32'h5555_5555);
        chk("R4 seed word 1", obs[2], 32'h5fff_ffff);
        chk("R4 seed word 2", obs[3], 32'h2a00_0000);
        chk("R4 seed word 3", obs[4], 32'h17a0_0000);
        chk("R4 seed word 4", obs[5], 32'h0aaa_0000);
        chk("R5 no output after gap beats", 32'(gap_emit), 0);

        // R6, R7: slip drifts by 7 bits
        rc0 = rcount;
        p += 7;
        push_fill(1); push(ALN); push_fill(2);
        flush(0);
        settle();
        chk("R6 single occurrence keeps slip", 32'(slip), 19);
        chk("R6 single occurrence no realign", 32'(rcount), 32'(rc0));
        push(ALN); push_fill(2);
        flush(0);
        settle();
        chk("R7 realign pulse count", 32'(rcount), 32'(rc0 + 1));
        chk("R7 slip moved", 32'(slip), 12);
        chk("R7 realign beat word", realign_word, ALN);

        // R6: candidate cancelled by alignment at the locked offset
        rc0 = rcount;
        p += 9;
        push_fill(1); push(ALN); push_fill(1);
        flush(0);
        p -= 9;
        push_fill(1); push(ALN); push_fill(1);
        flush(0);
        p += 9;
        push_fill(1); push(ALN); push_fill(2);
        flush(0);
        settle();
        chk("R6 interrupted pair keeps slip", 32'(slip), 12);
        chk("R6 interrupted pair no realign", 32'(rcount), 32'(rc0));
        push(ALN); push_fill(2);
        flush(0);
        settle();
        chk("R7 second consecutive moves slip", 32'(slip), 3);
        chk("R7 second consecutive realign", 32'(rcount), 32'(rc0 + 1));

        // R8: loss window boundary, drop, relock
        nd0 = ndrop;
        push(ALN); push_fill(LOSS - 1); push(ALN); push_fill(2);
        flush(10);
        settle();
        chk("R8 lock kept for LOSS-1 silent words", 32'(locked), 1);
        chk("R8 no drop inside window", 32'(ndrop), 32'(nd0));
        push_fill(20);
        flush(10);
        settle();
        chk("R8 lock dropped", 32'(locked), 0);
        chk("R8 one drop event", 32'(ndrop), 32'(nd0 + 1));
        chk("R8 words output before drop", 32'(since_align), 32'(LOSS - 1));
        push(ALN); push_fill(3);
        flush(0);
        settle();
        chk("R8 relock without reset", 32'(locked), 1);
        chk("R8 relock slip", 32'(slip), 3);

        // random traffic with drifting slip, gaps and losses
        for (int it = 0; it < 3000; it++) begin
            r = int'($urandom % 100);
            if (r < 5) begin
                delta = int'($urandom % 63) - 31;
                if (delta == 0) delta = 5;
                p += delta;
            end
            if (r < 2) push_fill(LOSS + 8);
            else if (($urandom % 6) == 0) push(ALN);
            else push(filler());
            flush(20);
        end
        settle();
        chk("R5 no output after gaps overall", 32'(gap_emit), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule